// File: doc/BRIEF.md
# PCIe Root Port Interrupt Aggregator

This block merges every interrupt source of a PCIe root port into a single interrupt line for the host CPU. It takes three kinds of source. Four legacy INTx wires are level inputs. Six error events are single-cycle pulses, three from the AXI side and three from the link side. Message-signalled interrupts arrive as a valid strobe with a data value, and that value names the vector.

Status is kept at two levels. A per-vector MSI status register records which vectors have fired. A single summary bit for it sits in the local status word, next to the INTx and error bits. Software reads and clears status through a small register port. It chooses which local bits reach the output through a mask register, and it reads the address that endpoints must target with MSI writes from a fixed read-only register. Every status bit is cleared by writing 1 to it.

Top module: `pcie_irq_agg`

## Requirements
- R1: After reset the local status, local mask and MSI status registers read 0, and `irq_o` is 0.
- R2: The register offsets are as follows: mask at 0x180, local status at 0x184, MSI target address at 0x190 and MSI status at 0x194. The MSI target address reads the parameter `MSI_TARGET_ADDR`, and writes to it are ignored. Any other offset reads 0.
- R3: An AXI-side post, fetch or discard error pulse sets local status bit 16, 17 or 18. The same three pulses on the link side set bit 20, 21 or 22. Each bit is readable in the cycle after the pulse.
- R4: INTA to INTD set local status bits 24 to 27 in every cycle the wire is high. If the wire is still high when software clears the bit, the bit reads 1 again.
- R5: Writing 1 to a local status bit clears it, and writing 0 to it leaves it unchanged. Writing 0xFFFFFFFF clears every bit that has no active source.
- R6: An MSI strobe whose data value v is below `NUM_VEC` sets MSI status bit v and local summary bit 28 on the next clock edge. A data value of `NUM_VEC` or more changes nothing.
- R7: Writing 1 to a bit of the MSI status register clears that bit, and writing 0 leaves it unchanged.
- R8: If the summary bit is cleared while any MSI status bit is still pending, it reads 1 in the following cycle. Once no MSI status bit is pending, clearing it leaves it at 0.
- R9: When a source event and a write-1-to-clear hit the same status bit in the same cycle, the event wins and the bit reads 1.
- R10: `irq_o` is the registered OR of (local status AND mask), so it follows a status change one cycle later. With the mask at 0, `irq_o` stays 0.
- R11: Only bits 16-18, 20-22 and 24-28 of the mask and local status registers are writable or settable. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| intx_i | input | 4 | Legacy INTA..INTD levels (bit 0 = INTA) |
| err_axi_i | input | 3 | AXI-side error pulses: post, fetch, discard |
| err_pcie_i | input | 3 | Link-side error pulses: post, fetch, discard |
| msi_valid_i | input | 1 | MSI write received this cycle |
| msi_data_i | input | MSI_DATA_W | MSI data value (vector number) |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt to the host |

## Verification
The bench uses the default parameters: 32 MSI vectors, a 16-bit MSI data field and a 12-bit register offset. With these values it can send vector 31, the highest one, and data value 40, which is out of range but still fits in the data field. At this width every bit of the MSI status register maps to a vector, so writing all ones to clear it is checked over the full word. Because the offsets are decoded in full 12 bits, the bench can probe an unmapped offset next to the mapped ones.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned REG_W = 32;

  localparam logic [11:0] OFF_MASK     = 12'h180;
  localparam logic [11:0] OFF_STAT     = 12'h184;
  localparam logic [11:0] OFF_MSI_ADDR = 12'h190;
  localparam logic [11:0] OFF_MSI_STAT = 12'h194;

  localparam int unsigned NUM_INTX     = 4;
  localparam int unsigned NUM_ERR      = 3;
  localparam int unsigned ERR_AXI_LSB  = 16;
  localparam int unsigned ERR_PCIE_LSB = 20;
  localparam int unsigned INTX_LSB     = 24;
  localparam int unsigned MSI_SUM_BIT  = 28;

  localparam logic [REG_W-1:0] LOCAL_IMPL = 32'h1F77_0000;

  typedef struct packed {
    logic             mask_we;
    logic [REG_W-1:0] mask_wdata;
    logic [REG_W-1:0] stat_clr;
  } loc_wr_t;
endpackage

// File: rtl/pirq_msi_bank.sv
module pirq_msi_bank #(
  parameter int unsigned NUM_VEC    = 32,
  parameter int unsigned MSI_DATA_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  msi_valid_i,
  input  logic [MSI_DATA_W-1:0] msi_data_i,
  input  logic [NUM_VEC-1:0]    clr_i,
  output logic [NUM_VEC-1:0]    stat_o,
  output logic                  event_o,
  output logic                  pend_o
);
  localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [NUM_VEC-1:0] stat_q, hit;
  logic               in_range;

  assign in_range = msi_data_i < MSI_DATA_W'(NUM_VEC);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign hit[v] = msi_valid_i && (msi_data_i == MSI_DATA_W'(v));
    // set beats clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[v] <= 1'b0;
      else         stat_q[v] <= (stat_q[v] & ~clr_i[v]) | hit[v];
    end
  end

  assign stat_o  = stat_q;
  assign event_o = msi_valid_i && in_range;
  assign pend_o  = |stat_q;

  logic [VEC_W-1:0] hit_idx;
  assign hit_idx = msi_data_i[VEC_W-1:0];

  p_msi_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msi_valid_i && in_range) |=> stat_q[$past(hit_idx)]);

  p_msi_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msi_valid_i && clr_i[0]) |=> !stat_q[0]);
endmodule

// File: rtl/pirq_local.sv
module pirq_local
  import pirq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_INTX-1:0] intx_i,
  input  logic [NUM_ERR-1:0]  err_axi_i,
  input  logic [NUM_ERR-1:0]  err_pcie_i,
  input  logic                msi_event_i,
  input  logic                msi_pend_i,
  input  loc_wr_t             wr_i,
  output logic [REG_W-1:0]    stat_o,
  output logic [REG_W-1:0]    mask_o,
  output logic                irq_o
);
  logic [REG_W-1:0] stat_q, mask_q, set_vec, stat_d;
  logic             irq_q;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NUM_ERR; i++) begin
      set_vec[ERR_AXI_LSB+i]  = err_axi_i[i];
      set_vec[ERR_PCIE_LSB+i] = err_pcie_i[i];
    end
    for (int k = 0; k < NUM_INTX; k++) set_vec[INTX_LSB+k] = intx_i[k];
    // summary re-arms while any vector is still pending
    set_vec[MSI_SUM_BIT] = msi_event_i | msi_pend_i;
    stat_d = ((stat_q & ~wr_i.stat_clr) | set_vec) & LOCAL_IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (wr_i.mask_we) mask_q <= wr_i.mask_wdata & LOCAL_IMPL;
      irq_q  <= |(stat_q & mask_q);
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  for (genvar k = 0; k < NUM_INTX; k++) begin : g_intx_chk
    p_intx_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      intx_i[k] |=> stat_q[INTX_LSB+k]);
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err_chk
    p_err_axi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_axi_i[i] |=> stat_q[ERR_AXI_LSB+i]);
    p_err_pcie_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_pcie_i[i] |=> stat_q[ERR_PCIE_LSB+i]);
  end

  p_event_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_pcie_i[0] && wr_i.stat_clr[ERR_PCIE_LSB]) |=> stat_q[ERR_PCIE_LSB]);

  p_sum_rearm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_pend_i |=> stat_q[MSI_SUM_BIT]);

  p_irq_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_q & mask_q)) |=> irq_q);

  p_mask_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !irq_q);
endmodule

// File: rtl/pirq_regif.sv
module pirq_regif
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_VEC         = 32,
  parameter int unsigned ADDR_W          = 12,
  parameter logic [31:0] MSI_TARGET_ADDR = 32'h0F00_0040
) (
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_wr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  input  logic [REG_W-1:0]   loc_stat_i,
  input  logic [REG_W-1:0]   loc_mask_i,
  input  logic [NUM_VEC-1:0] msi_stat_i,
  output loc_wr_t            loc_wr_o,
  output logic [NUM_VEC-1:0] msi_clr_o,
  output logic [REG_W-1:0]   reg_rdata_o
);
  logic sel_mask, sel_stat, sel_addr, sel_msi;

  assign sel_mask = reg_addr_i == ADDR_W'(OFF_MASK);
  assign sel_stat = reg_addr_i == ADDR_W'(OFF_STAT);
  assign sel_addr = reg_addr_i == ADDR_W'(OFF_MSI_ADDR);
  assign sel_msi  = reg_addr_i == ADDR_W'(OFF_MSI_STAT);

  always_comb begin
    loc_wr_o.mask_we    = reg_wr_i && sel_mask;
    loc_wr_o.mask_wdata = reg_wdata_i;
    loc_wr_o.stat_clr   = (reg_wr_i && sel_stat) ? reg_wdata_i : '0;
    msi_clr_o           = (reg_wr_i && sel_msi) ? reg_wdata_i[NUM_VEC-1:0] : '0;
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (1'b1)
      sel_mask: reg_rdata_o = loc_mask_i;
      sel_stat: reg_rdata_o = loc_stat_i;
      sel_addr: reg_rdata_o = MSI_TARGET_ADDR;
      sel_msi:  reg_rdata_o[NUM_VEC-1:0] = msi_stat_i;
      default:  reg_rdata_o = '0;
    endcase
  end

  always_comb begin
    a_onehot_sel_r2: assert ($onehot0({sel_mask, sel_stat, sel_addr, sel_msi}));
  end
endmodule

// File: rtl/pcie_irq_agg.sv
module pcie_irq_agg
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_VEC         = 32,
  parameter int unsigned MSI_DATA_W      = 16,
  parameter int unsigned ADDR_W          = 12,
  parameter logic [31:0] MSI_TARGET_ADDR = 32'h0F00_0040
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [3:0]            intx_i,
  input  logic [2:0]            err_axi_i,
  input  logic [2:0]            err_pcie_i,
  input  logic                  msi_valid_i,
  input  logic [MSI_DATA_W-1:0] msi_data_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic                  reg_wr_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  output logic                  irq_o
);
  loc_wr_t            loc_wr;
  logic [NUM_VEC-1:0] msi_clr, msi_stat;
  logic [REG_W-1:0]   loc_stat, loc_mask;
  logic               msi_event, msi_pend;

  pirq_regif #(
    .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .MSI_TARGET_ADDR(MSI_TARGET_ADDR)
  ) u_regif (
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .reg_wdata_i(reg_wdata_i),
    .loc_stat_i (loc_stat),
    .loc_mask_i (loc_mask),
    .msi_stat_i (msi_stat),
    .loc_wr_o   (loc_wr),
    .msi_clr_o  (msi_clr),
    .reg_rdata_o(reg_rdata_o)
  );

  pirq_msi_bank #(.NUM_VEC(NUM_VEC), .MSI_DATA_W(MSI_DATA_W)) u_msi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msi_valid_i(msi_valid_i),
    .msi_data_i (msi_data_i),
    .clr_i      (msi_clr),
    .stat_o     (msi_stat),
    .event_o    (msi_event),
    .pend_o     (msi_pend)
  );

  pirq_local u_local (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .intx_i     (intx_i),
    .err_axi_i  (err_axi_i),
    .err_pcie_i (err_pcie_i),
    .msi_event_i(msi_event),
    .msi_pend_i (msi_pend),
    .wr_i       (loc_wr),
    .stat_o     (loc_stat),
    .mask_o     (loc_mask),
    .irq_o      (irq_o)
  );
endmodule

// File: tb/pcie_irq_agg_bench.sv
module pcie_irq_agg_bench;
  localparam logic [31:0] TGT = 32'h0F00_0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx = '0;
  logic [2:0]  e_axi = '0, e_pcie = '0;
  logic        m_valid = 1'b0;
  logic [15:0] m_data = '0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pcie_irq_agg u_pcie_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .intx_i(intx), .err_axi_i(e_axi),
    .err_pcie_i(e_pcie), .msi_valid_i(m_valid), .msi_data_i(m_data),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr_reg(logic [11:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    cyc();
    wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h180, d); chk("R1 mask", d, 0);
    rd(12'h184, d); chk("R1 stat", d, 0);
    rd(12'h194, d); chk("R1 msi", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(12'h190, d); chk("R2 msi addr", d, TGT);
  endtask

  task automatic t_errors();
    logic [31:0] d;
    e_axi = 3'b101; e_pcie = 3'b010;
    cyc();
    e_axi = '0; e_pcie = '0;
    rd(12'h184, d); chk("R3 err bits", d, 32'h0025_0000);
    cyc(); chk("R10 unmasked irq", {31'b0, irq}, 0);
    wr_reg(12'h180, 32'h0004_0000);
    cyc(); chk("R10 masked irq", {31'b0, irq}, 1);
    wr_reg(12'h184, 32'h0001_0000);
    rd(12'h184, d); chk("R5 w1c single", d, 32'h0024_0000);
    wr_reg(12'h184, 32'hFFFF_FFFF);
    rd(12'h184, d); chk("R5 clear all", d, 0);
    cyc(); chk("R10 irq drop", {31'b0, irq}, 0);
  endtask

  task automatic t_intx();
    logic [31:0] d;
    intx = 4'b0110;
    cyc();
    rd(12'h184, d); chk("R4 intx set", d, 32'h0600_0000);
    wr_reg(12'h184, 32'h0600_0000);
    rd(12'h184, d); chk("R4 level reset", d, 32'h0600_0000);
    intx = '0;
    wr_reg(12'h184, 32'h0600_0000);
    rd(12'h184, d); chk("R4 released", d, 0);
  endtask

  task automatic send_msi(logic [15:0] v);
    m_valid = 1'b1; m_data = v;
    cyc();
    m_valid = 1'b0;
  endtask

  task automatic t_msi();
    logic [31:0] d;
    send_msi(16'd5);
    rd(12'h194, d); chk("R6 vec5", d, 32'h0000_0020);
    rd(12'h184, d); chk("R6 summary", d, 32'h1000_0000);
    send_msi(16'd31);
    rd(12'h194, d); chk("R6 vec31", d, 32'h8000_0020);
    send_msi(16'd40);
    rd(12'h194, d); chk("R6 out of range", d, 32'h8000_0020);
    wr_reg(12'h184, 32'h1000_0000);
    rd(12'h184, d); chk("R8 rearm", d, 32'h1000_0000);
    wr_reg(12'h194, 32'h0000_0020);
    rd(12'h194, d); chk("R7 clear vec5", d, 32'h8000_0000);
    wr_reg(12'h194, 32'hFFFF_FFFF);
    rd(12'h194, d); chk("R7 clear all", d, 0);
    wr_reg(12'h184, 32'h1000_0000);
    rd(12'h184, d); chk("R8 summary cleared", d, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    e_pcie = 3'b001;
    wr_reg(12'h184, 32'h0010_0000);
    e_pcie = '0;
    rd(12'h184, d); chk("R9 err wins", d, 32'h0010_0000);
    wr_reg(12'h184, 32'hFFFF_FFFF);
    send_msi(16'd3);
    m_valid = 1'b1; m_data = 16'd3;
    wr_reg(12'h194, 32'h0000_0008);
    m_valid = 1'b0;
    rd(12'h194, d); chk("R9 msi wins", d, 32'h0000_0008);
    wr_reg(12'h194, 32'hFFFF_FFFF);
    wr_reg(12'h184, 32'hFFFF_FFFF);
    rd(12'h184, d); chk("R9 cleanup", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr_reg(12'h180, 32'hFFFF_FFFF);
    rd(12'h180, d); chk("R11 mask impl", d, 32'h1F77_0000);
    wr_reg(12'h190, 32'h1234_5678);
    rd(12'h190, d); chk("R2 ro addr", d, TGT);
    rd(12'h100, d); chk("R2 unmapped", d, 0);
    wr_reg(12'h184, 32'hFFFF_FFFF);
    rd(12'h184, d); chk("R11 stat impl", d, 0);
    wr_reg(12'h180, 32'h0100_0000);
    intx = 4'b0001;
    cyc();
    chk("R10 latency early", {31'b0, irq}, 0);
    cyc();
    chk("R10 latency", {31'b0, irq}, 1);
    wr_reg(12'h180, 32'h0);
    cyc(); cyc();
    chk("R10 mask zero", {31'b0, irq}, 0);
    intx = '0;
    wr_reg(12'h184, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_errors();
    t_intx();
    t_msi();
    t_collide();
    t_regs();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule